// File: doc/BRIEF.md
# Static Dataflow Operator Node

This block is one two-operand arithmetic node of a static dataflow graph. Each of its two input arcs and its output arc is a single-token register slot. A token enters an input slot through a valid/ready transfer. The node fires only when both input slots hold a token and the output slot is free. Firing removes both operands and places the result in the output slot on the same clock edge. A downstream consumer takes the result with its own valid/ready transfer.

Because no arc can hold more than one token, only one iteration is live on any arc, and tokens carry no tag. A 2-bit operation select input chooses the function used at the firing edge: sum, difference, or a test of the left operand against zero.

Nodes of this kind can be wired head to tail to form a pipeline. Unrelated nodes fire in the same cycle, and successive nodes in a chain work on successive tokens of one stream.

Top module: `dflow_node`

## Requirements
- R1: While reset is asserted and after it is released, all three slots are empty: `a_ready_o` and `b_ready_o` are 1 and `y_valid_o` is 0.
- R2: An input's ready output is 1 exactly when its slot is empty. A transfer (valid and ready both high at a clock edge) fills the slot, and ready then stays 0 until that token is consumed, so a slot never holds two tokens.
- R3: The node never fires while either input slot is empty. A token on one input alone produces no output, however long it waits.
- R4: When both input slots are full, the node fires only if the output slot is empty or is being emptied on the same edge. While the output stays full with `y_ready_i` low, both inputs stay full. A drain and a fire on the same edge leave `y_valid_o` at 1 with the new result.
- R5: A firing edge empties both input slots and fills the output slot, so after it `a_ready_o`, `b_ready_o` and `y_valid_o` are all 1.
- R6: With `op_i` = 2'b00 at the firing edge, the result is (left + right) modulo 2^W.
- R7: With `op_i` = 2'b01 at the firing edge, the result is (left - right) modulo 2^W.
- R8: With `op_i[1]` = 1 at the firing edge, the result is 1 when the left operand is nonzero and 0 otherwise. The right operand is consumed but has no effect on the result.
- R9: A result in the output slot keeps `y_valid_o` at 1 and `y_data_o` unchanged until a transfer with `y_ready_i` high, after which the slot is empty unless it was refilled on that edge.
- R10: With both inputs always valid and `y_ready_i` held high, the node delivers exactly one result every two cycles. Results leave in the order their operand pairs arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation select: 00 sum, 01 difference, 1x nonzero test |
| a_valid_i | input | 1 | Left operand token offered |
| a_data_i | input | W | Left operand value |
| a_ready_o | output | 1 | Left input slot empty |
| b_valid_i | input | 1 | Right operand token offered |
| b_data_i | input | W | Right operand value |
| b_ready_o | output | 1 | Right input slot empty |
| y_valid_o | output | 1 | Output slot holds a result |
| y_data_o | output | W | Result value |
| y_ready_i | input | 1 | Consumer takes the result |

## Verification
The hardest case to reach is the edge where a full output slot is drained while both input slots are full. On that edge the node must drain and fire together, with no bubble. Random traffic reaches it only when backpressure lines up with both operands already being parked. A directed sequence therefore fills both inputs behind a stalled output, holds the stall for several cycles, and then pulses `y_ready_i` for one cycle. Random phases with a fixed op per phase, independent input valids and bursty `y_ready_i` then exercise the same edge many times against an in-order scoreboard.

// File: rtl/dflow_pkg.sv
package dflow_pkg;
  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_SUB    = 2'b01,
    OP_NZ     = 2'b10,
    OP_NZ_ALT = 2'b11
  } op_e;
endpackage

// File: rtl/dflow_slot.sv
// One-token arc register.
module dflow_slot #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_i,
  input  logic [W-1:0] fill_data_i,
  input  logic         drain_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else if (fill_i) begin
      full_q <= 1'b1;
    end else if (drain_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (fill_i) begin
      data_q <= fill_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/dflow_fire_ctl.sv
// Static firing rule: all inputs present, output free (or freed this edge).
module dflow_fire_ctl #(
  parameter int N_IN = 2
) (
  input  logic [N_IN-1:0] in_full_i,
  input  logic            out_full_i,
  input  logic            out_drain_i,
  output logic            enabled_o,
  output logic            fire_o
);
  logic out_free;

  assign enabled_o = &in_full_i;
  assign out_free  = ~out_full_i | out_drain_i;
  assign fire_o    = enabled_o & out_free;
endmodule

// File: rtl/dflow_alu.sv
module dflow_alu
  import dflow_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  res_o = lhs_i + rhs_i;
      OP_SUB:  res_o = lhs_i - rhs_i;
      default: res_o = {{(W-1){1'b0}}, |lhs_i};
    endcase
  end
endmodule

// File: rtl/dflow_node.sv
module dflow_node
  import dflow_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic         a_valid_i,
  input  logic [W-1:0] a_data_i,
  output logic         a_ready_o,
  input  logic         b_valid_i,
  input  logic [W-1:0] b_data_i,
  output logic         b_ready_o,
  output logic         y_valid_o,
  output logic [W-1:0] y_data_o,
  input  logic         y_ready_i
);
  localparam int N_IN = 2;

  logic [N_IN-1:0]        in_valid;
  logic [N_IN-1:0][W-1:0] in_wdata;
  logic [N_IN-1:0]        in_full;
  logic [N_IN-1:0][W-1:0] in_data;
  logic [N_IN-1:0]        in_accept;

  logic         fire;
  logic         enabled;
  logic         out_full;
  logic         out_drain;
  logic [W-1:0] out_data;
  logic [W-1:0] alu_res;
  op_e          op;

  assign in_valid = {b_valid_i, a_valid_i};
  assign in_wdata = {b_data_i, a_data_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    // ready only when empty: no same-edge refill of an input arc
    assign in_accept[g] = in_valid[g] & ~in_full[g];

    dflow_slot #(.W(W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_i      (in_accept[g]),
      .fill_data_i (in_wdata[g]),
      .drain_i     (fire),
      .full_o      (in_full[g]),
      .data_o      (in_data[g])
    );
  end

  assign out_drain = out_full & y_ready_i;

  dflow_fire_ctl #(.N_IN(N_IN)) u_fire (
    .in_full_i   (in_full),
    .out_full_i  (out_full),
    .out_drain_i (out_drain),
    .enabled_o   (enabled),
    .fire_o      (fire)
  );

  assign op = op_e'(op_i);

  dflow_alu #(.W(W)) u_alu (
    .op_i  (op),
    .lhs_i (in_data[0]),
    .rhs_i (in_data[1]),
    .res_o (alu_res)
  );

  dflow_slot #(.W(W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fire),
    .fill_data_i (alu_res),
    .drain_i     (out_drain),
    .full_o      (out_full),
    .data_o      (out_data)
  );

  assign a_ready_o = ~in_full[0];
  assign b_ready_o = ~in_full[1];
  assign y_valid_o = out_full;
  assign y_data_o  = out_data;
endmodule

// File: rtl/dflow_node_chk.sv
module dflow_node_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   op_i,
  input logic         a_valid_i,
  input logic         a_ready_o,
  input logic         b_valid_i,
  input logic         b_ready_o,
  input logic         y_valid_o,
  input logic [W-1:0] y_data_o,
  input logic         y_ready_i,
  input logic [W-1:0] slot_a,
  input logic [W-1:0] slot_b
);
  logic both_full, out_free;
  assign both_full = !a_ready_o && !b_ready_o;
  assign out_free  = !y_valid_o || y_ready_i;

  p_a_one_token_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o) |=> !a_ready_o);
  p_b_one_token_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_i && b_ready_o) |=> !b_ready_o);
  p_no_fire_a_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ready_o && !y_valid_o) |=> !y_valid_o);
  p_no_fire_b_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_ready_o && !y_valid_o) |=> !y_valid_o);
  p_blocked_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i && both_full) |=> both_full);
  p_fire_consume_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_full && out_free) |=> (a_ready_o && b_ready_o && y_valid_o));
  p_add_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_full && out_free && op_i == 2'b00) |=> (y_data_o == $past(slot_a + slot_b)));
  p_sub_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_full && out_free && op_i == 2'b01) |=> (y_data_o == $past(slot_a - slot_b)));
  p_nz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_full && out_free && op_i[1]) |=> (y_data_o == W'($past(slot_a != '0))));
  p_out_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i) |=> (y_valid_o && $stable(y_data_o)));
endmodule

bind dflow_node dflow_node_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .a_valid_i (a_valid_i),
  .a_ready_o (a_ready_o),
  .b_valid_i (b_valid_i),
  .b_ready_o (b_ready_o),
  .y_valid_o (y_valid_o),
  .y_data_o  (y_data_o),
  .y_ready_i (y_ready_i),
  .slot_a    (in_data[0]),
  .slot_b    (in_data[1])
);

// File: tb/dflow_node_bench.sv
`timescale 1ns/1ps
module dflow_node_bench;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic         a_valid_i = 1'b0, b_valid_i = 1'b0, y_ready_i = 1'b0;
  logic [W-1:0] a_data_i = '0, b_data_i = '0;
  logic         a_ready_o, b_ready_o, y_valid_o;
  logic [W-1:0] y_data_o;

  int n_chk = 0, n_bad = 0, n_out = 0;
  bit done = 0;
  logic [W-1:0] q_a[$], q_b[$];

  always #4 clk_i = ~clk_i;

  dflow_node #(.W(W)) u_dflow_node (
    .clk_i, .rst_ni, .op_i,
    .a_valid_i, .a_data_i, .a_ready_o,
    .b_valid_i, .b_data_i, .b_ready_o,
    .y_valid_o, .y_data_o, .y_ready_i
  );

  function automatic logic [W-1:0] calc(logic [1:0] op, logic [W-1:0] l, logic [W-1:0] r);
    if (op[1]) return W'(l != '0);
    if (op[0]) return l - r;
    return l + r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs already driven at negedge; record transfers of the coming edge
  task automatic step();
    #1;
    if (y_valid_o && y_ready_i) begin
      n_out++;
      if (q_a.size() == 0 || q_b.size() == 0) check("R3 result without pair", 1, 0);
      else begin
        check("R6/R7/R8/R10 result in order", y_data_o, calc(op_i, q_a[0], q_b[0]));
        void'(q_a.pop_front());
        void'(q_b.pop_front());
      end
    end
    if (a_valid_i && a_ready_o) q_a.push_back(a_data_i);
    if (b_valid_i && b_ready_o) q_b.push_back(b_data_i);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle_in();
    a_valid_i = 0; b_valid_i = 0;
  endtask

  task automatic drain_all();
    int guard = 0;
    while ((q_a.size() > 0 || q_b.size() > 0 || y_valid_o) && guard < 1000) begin
      a_valid_i = q_a.size() < q_b.size();
      b_valid_i = q_b.size() < q_a.size();
      a_data_i  = W'($urandom);
      b_data_i  = W'($urandom);
      y_ready_i = 1;
      step();
      guard++;
    end
    idle_in();
    y_ready_i = 0;
    check("R9 drained", y_valid_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1 a_ready in reset", a_ready_o, 1);
    check("R1 y_valid in reset", y_valid_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 a_ready", a_ready_o, 1);
    check("R1 b_ready", b_ready_o, 1);
    check("R1 y_valid", y_valid_o, 0);

    // left operand alone
    a_valid_i = 1; a_data_i = 16'd10;
    step();
    idle_in();
    check("R2 a_ready low when full", a_ready_o, 0);
    check("R2 b_ready still high", b_ready_o, 1);
    repeat (3) step();
    check("R3 no fire with one operand", y_valid_o, 0);
    check("R2 a stays full", a_ready_o, 0);

    b_valid_i = 1; b_data_i = 16'd20;
    step();
    idle_in();
    check("R3 fire not yet", y_valid_o, 0);
    step();
    check("R5 a consumed", a_ready_o, 1);
    check("R5 b consumed", b_ready_o, 1);
    check("R5 result produced", y_valid_o, 1);
    check("R6 sum", y_data_o, 30);

    // park operands behind a stalled output
    a_valid_i = 1; a_data_i = 16'd7; b_valid_i = 1; b_data_i = 16'd1;
    step();
    idle_in();
    repeat (3) step();
    check("R4 a held while blocked", a_ready_o, 0);
    check("R4 b held while blocked", b_ready_o, 0);
    check("R9 valid held", y_valid_o, 1);
    check("R9 data held", y_data_o, 30);
    y_ready_i = 1;
    step();
    check("R4 drain+fire keeps valid", y_valid_o, 1);
    check("R4 drain+fire new data", y_data_o, 8);
    check("R4 inputs freed", a_ready_o & b_ready_o, 1);
    step();
    y_ready_i = 0;
    check("R9 emptied after transfer", y_valid_o, 0);

    op_i = 2'b01;
    a_valid_i = 1; a_data_i = 16'd3; b_valid_i = 1; b_data_i = 16'd5;
    step(); idle_in(); step();
    check("R7 difference wraps", y_data_o, 16'hFFFE);
    y_ready_i = 1; step(); y_ready_i = 0;

    op_i = 2'b10;
    a_valid_i = 1; a_data_i = 16'd0; b_valid_i = 1; b_data_i = 16'd9;
    step(); idle_in(); step();
    check("R8 zero left gives 0", y_data_o, 0);
    y_ready_i = 1; step(); y_ready_i = 0;
    op_i = 2'b11;
    a_valid_i = 1; a_data_i = 16'h8000; b_valid_i = 1; b_data_i = 16'd0;
    step(); idle_in(); step();
    check("R8 nonzero left gives 1", y_data_o, 1);
    y_ready_i = 1; step(); y_ready_i = 0;
    check("R9 empty after take", y_valid_o, 0);

    // sustained flow
    op_i = 2'b00;
    y_ready_i = 1; a_valid_i = 1; b_valid_i = 1;
    for (int i = 0; i < 6; i++) begin
      a_data_i = W'(i * 3); b_data_i = W'(i + 100); step();
    end
    n_out = 0;
    for (int i = 0; i < 20; i++) begin
      a_data_i = W'(i * 7); b_data_i = W'(i + 11); step();
    end
    check("R10 one result per two cycles", n_out, 10);
    idle_in();
    drain_all();

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      op_i = 2'(ph);
      for (int c = 0; c < 1500; c++) begin
        a_valid_i = ($urandom % 3) != 0;
        b_valid_i = ($urandom % 3) != 0;
        a_data_i  = ($urandom % 8 == 0) ? '0 : W'($urandom);
        b_data_i  = W'($urandom);
        y_ready_i = ($urandom % 4) != 0;
        if (c % 200 > 185) y_ready_i = 0;
        step();
      end
      idle_in();
      drain_all();
    end

    finish_run();
  end
endmodule